// File: doc/BRIEF.md
# Condition Flag Register and Flag-Based Branch Resolver

This block sits beside an ALU. Each arithmetic, logic or compare operation presents its result together with a write strobe, and the block stores two condition flags from that result: a sign flag (the top bit) and a zero flag (all bits clear). A compare is an ordinary subtraction whose result goes nowhere else; it uses the same strobe, so it only refreshes the flags.

A later branch raises a valid strobe and names a condition. The block judges the condition against the flags that were stored before that cycle's clock edge and reports the decision one cycle later on a registered output with its own done strobe. A write and a branch presented together are legal: the branch sees the older flags and the write lands at the same edge. Target address calculation, register writeback and the ALU are outside the block.

Top module: `ccr_branch_unit`

## Requirements
- R1: On a clock edge with `flag_wr` high, `flag_sign` takes bit DATA_W-1 of `alu_result` (1 means negative, 0 means zero or positive), visible after that edge.
- R2: On a clock edge with `flag_wr` high, `flag_zero` becomes 1 when `alu_result` is all zeros and 0 otherwise.
- R3: While `flag_wr` is low both flags hold their values, whatever `alu_result`, `br_valid` or `br_cond` do.
- R4: Condition code 0 (less than) is taken exactly when the sign flag is 1.
- R5: Condition code 1 (greater than) is taken exactly when sign is 0 and zero is 0.
- R6: Condition code 2 (greater or equal) is taken when sign is 0; code 3 (less or equal) is taken when sign is 1 or zero is 1.
- R7: Condition code 4 (equal) is taken when zero is 1; code 5 (not equal) is taken when zero is 0.
- R8: Condition code 6 is taken unconditionally; code 7 is never taken.
- R9: A branch sampled at an edge is judged on the flags held before that edge, even if a flag write happens at the same edge; `br_done` is 1 and `br_taken` carries the decision in the cycle after the branch.
- R10: Synchronous active-high reset clears `flag_sign`, `flag_zero`, `br_done` and `br_taken`.
- R11: After an edge with `br_valid` low, `br_done` and `br_taken` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_wr | input | 1 | Result of an arithmetic, logic or compare operation is present |
| alu_result | input | DATA_W | Result from the ALU |
| br_valid | input | 1 | A flag-based branch is being resolved this cycle |
| br_cond | input | 3 | Condition code of the branch |
| flag_sign | output | 1 | Stored sign flag |
| flag_zero | output | 1 | Stored zero flag |
| br_done | output | 1 | A decision is presented this cycle |
| br_taken | output | 1 | Decision for the branch of the previous cycle |

## Verification
The bench builds the block with the default DATA_W of 32, so the exact sign boundary values (the most negative word, the largest positive word, all ones and zero) are driven and each of the eight condition codes is resolved against every flag combination they produce. It also places a write and a branch in the same cycle, where a design that forwards the new flags would decide differently, and runs idle stretches with changing results and branches to show the flags hold.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int COND_W = 3;

  typedef enum logic [COND_W-1:0] {
    CC_LT     = 3'd0,
    CC_GT     = 3'd1,
    CC_GE     = 3'd2,
    CC_LE     = 3'd3,
    CC_EQ     = 3'd4,
    CC_NE     = 3'd5,
    CC_ALWAYS = 3'd6,
    CC_NEVER  = 3'd7
  } cond_e;

  typedef struct packed {
    logic sign;
    logic zero;
  } flags_t;
endpackage

// File: rtl/ccr_flag_store.sv
module ccr_flag_store #(
  parameter int DATA_W  = 32,
  parameter int CHUNK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] result,
  output ccr_pkg::flags_t   flags
);
  localparam int NCHUNK = (DATA_W + CHUNK_W - 1) / CHUNK_W;
  localparam int PAD_W  = NCHUNK * CHUNK_W;

  logic [PAD_W-1:0]  padded;
  logic [NCHUNK-1:0] chunk_nz;
  logic              any_set;

  assign padded = PAD_W'(result);

  // zero detect as a two-level OR tree: per-chunk reduce, then combine
  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign chunk_nz[g] = |padded[g*CHUNK_W +: CHUNK_W];
  end
  assign any_set = |chunk_nz;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (wr_en) begin
      flags.sign <= result[DATA_W-1];
      flags.zero <= ~any_set;
    end
  end
endmodule

// File: rtl/ccr_cond_eval.sv
module ccr_cond_eval (
  input  ccr_pkg::cond_e  cond,
  input  ccr_pkg::flags_t flags,
  output logic            take
);
  import ccr_pkg::*;

  always_comb begin
    unique case (cond)
      CC_LT:     take = flags.sign;
      CC_GT:     take = ~flags.sign & ~flags.zero;
      CC_GE:     take = ~flags.sign;
      CC_LE:     take = flags.sign | flags.zero;
      CC_EQ:     take = flags.zero;
      CC_NE:     take = ~flags.zero;
      CC_ALWAYS: take = 1'b1;
      default:   take = 1'b0;
    endcase
  end
endmodule

// File: rtl/ccr_decision_reg.sv
module ccr_decision_reg (
  input  logic clk,
  input  logic rst,
  input  logic valid_in,
  input  logic take_in,
  output logic done,
  output logic taken
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      taken <= 1'b0;
    end else begin
      done  <= valid_in;
      taken <= valid_in & take_in;
    end
  end
endmodule

// File: rtl/ccr_branch_unit.sv
module ccr_branch_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_wr,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              br_valid,
  input  logic [2:0]        br_cond,
  output logic              flag_sign,
  output logic              flag_zero,
  output logic              br_done,
  output logic              br_taken
);
  import ccr_pkg::*;

  flags_t cur_flags;
  logic   decide;
  cond_e  cond_q;

  assign cond_q = cond_e'(br_cond);

  ccr_flag_store #(.DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (flag_wr),
    .result (alu_result),
    .flags  (cur_flags)
  );

  // branch reads the stored flags, never the result entering this cycle
  ccr_cond_eval u_eval (
    .cond  (cond_q),
    .flags (cur_flags),
    .take  (decide)
  );

  ccr_decision_reg u_dec (
    .clk      (clk),
    .rst      (rst),
    .valid_in (br_valid),
    .take_in  (decide),
    .done     (br_done),
    .taken    (br_taken)
  );

  assign flag_sign = cur_flags.sign;
  assign flag_zero = cur_flags.zero;
endmodule

// File: rtl/ccr_branch_checker.sv
module ccr_branch_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              flag_wr,
  input logic [DATA_W-1:0] alu_result,
  input logic              br_valid,
  input logic [2:0]        br_cond,
  input logic              flag_sign,
  input logic              flag_zero,
  input logic              br_done,
  input logic              br_taken
);
  p_sign_r1: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> flag_sign == $past(alu_result[DATA_W-1]));

  p_zero_r2: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> flag_zero == ($past(alu_result) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !flag_wr |=> ($stable(flag_sign) && $stable(flag_zero)));

  p_lt_r4: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_cond == 3'd0) |=> br_taken == $past(flag_sign));

  p_gt_r5: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_cond == 3'd1) |=> br_taken == $past(!flag_sign && !flag_zero));

  p_le_r6: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_cond == 3'd3) |=> br_taken == $past(flag_sign || flag_zero));

  p_eq_r7: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_cond == 3'd4) |=> br_taken == $past(flag_zero));

  p_always_r8: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_cond == 3'd6) |=> br_taken);

  p_never_r8: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_cond == 3'd7) |=> !br_taken);

  p_done_r9: assert property (@(posedge clk) disable iff (rst)
    br_valid |=> br_done);

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!flag_sign && !flag_zero && !br_done && !br_taken));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> (!br_done && !br_taken));
endmodule

bind ccr_branch_unit ccr_branch_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flag_wr    (flag_wr),
  .alu_result (alu_result),
  .br_valid   (br_valid),
  .br_cond    (br_cond),
  .flag_sign  (flag_sign),
  .flag_zero  (flag_zero),
  .br_done    (br_done),
  .br_taken   (br_taken)
);

// File: tb/test_ccr_branch_unit.sv
module test_ccr_branch_unit;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              flag_wr = 1'b0;
  logic [DATA_W-1:0] alu_result = '0;
  logic              br_valid = 1'b0;
  logic [2:0]        br_cond = '0;
  logic              flag_sign, flag_zero, br_done, br_taken;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit    is_br;
    bit    exp_taken;
    bit    exp_s;
    bit    exp_z;
    string tag;
  } item_t;

  item_t sb[$];
  bit    ms = 1'b0;
  bit    mz = 1'b0;

  always #4 clk = ~clk;

  ccr_branch_unit #(.DATA_W(DATA_W)) i_ccr_branch_unit (
    .clk(clk), .rst(rst), .flag_wr(flag_wr), .alu_result(alu_result),
    .br_valid(br_valid), .br_cond(br_cond), .flag_sign(flag_sign),
    .flag_zero(flag_zero), .br_done(br_done), .br_taken(br_taken)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_take(input int c, input bit s, input bit z);
    case (c)
      0: return s;            // R4
      1: return !s && !z;     // R5
      2: return !s;           // R6
      3: return s || z;       // R6
      4: return z;            // R7
      5: return !z;           // R7
      6: return 1'b1;         // R8
      default: return 1'b0;   // R8
    endcase
  endfunction

  // driver: one cycle of stimulus and its expected outcome
  task automatic step(input bit we, input logic [DATA_W-1:0] res,
                      input bit bv, input int c, input string tag);
    item_t it;
    @(negedge clk);
    flag_wr    = we;
    alu_result = res;
    br_valid   = bv;
    br_cond    = 3'(c);
    it.is_br     = bv;
    it.exp_taken = bv ? model_take(c, ms, mz) : 1'b0;
    if (we) begin
      ms = res[DATA_W-1];
      mz = (res == '0);
    end
    it.exp_s = ms;
    it.exp_z = mz;
    it.tag   = tag;
    sb.push_back(it);
  endtask

  task automatic all_conds(input string tag);
    for (int c = 0; c < 8; c++) step(1'b0, 32'h1234_5678, 1'b1, c, tag);
  endtask

  task automatic do_reset();
    step(1'b0, '0, 1'b0, 0, "R11");
    @(negedge clk);
    rst = 1'b1; flag_wr = 1'b0; br_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    ms = 1'b0; mz = 1'b0;
    check(flag_sign == 1'b0, "R10 sign", flag_sign, 0);
    check(flag_zero == 1'b0, "R10 zero", flag_zero, 0);
    check(br_done == 1'b0,   "R10 done", br_done, 0);
    check(br_taken == 1'b0,  "R10 taken", br_taken, 0);
  endtask

  // monitor: pops one expectation per clock after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(flag_sign == it.exp_s, {it.tag, " R1 sign"}, flag_sign, it.exp_s);
        check(flag_zero == it.exp_z, {it.tag, " R2 zero"}, flag_zero, it.exp_z);
        if (it.is_br) begin
          check(br_done == 1'b1, {it.tag, " R9 done"}, br_done, 1);
          check(br_taken == it.exp_taken, {it.tag, " taken"}, br_taken, it.exp_taken);
        end else begin
          check(br_done == 1'b0 && br_taken == 1'b0, {it.tag, " R11 idle"},
                {br_done, br_taken}, 0);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(flag_sign == 1'b0, "R10 sign", flag_sign, 0);
    check(flag_zero == 1'b0, "R10 zero", flag_zero, 0);
    check(br_done == 1'b0,   "R10 done", br_done, 0);

    all_conds("R8 after reset");
    step(1'b1, 32'd5, 1'b0, 0, "R1 positive");
    all_conds("R5 positive");
    step(1'b1, 32'h8000_0000, 1'b0, 0, "R1 most negative");
    all_conds("R4 negative");
    step(1'b1, 32'h0000_0000, 1'b0, 0, "R2 zero");
    all_conds("R7 zero");
    step(1'b1, 32'hFFFF_FFFF, 1'b0, 0, "R1 all ones");
    all_conds("R6 minus one");
    step(1'b1, 32'h7FFF_FFFF, 1'b0, 0, "R1 largest positive");
    all_conds("R6 largest positive");

    // R9: write zero and branch-if-equal in the same cycle: old flags rule
    step(1'b1, 32'h0, 1'b1, 4, "R9 same cycle EQ");
    step(1'b0, 32'h1, 1'b1, 4, "R9 next cycle EQ");
    step(1'b1, 32'h8000_0001, 1'b1, 0, "R9 same cycle LT");
    step(1'b0, 32'h0, 1'b1, 0, "R9 next cycle LT");

    // R3: idle and branching cycles with changing results must not move flags
    for (int i = 0; i < 6; i++)
      step(1'b0, 32'(i * 32'h1357_9BDF), i[0], i % 8, "R3 hold");

    // back-to-back writes, each followed by a branch
    step(1'b1, 32'h40, 1'b1, 1, "R5 b2b");
    step(1'b1, 32'h0, 1'b1, 1, "R5 b2b");
    step(1'b0, 32'h0, 1'b1, 3, "R6 b2b");

    do_reset();
    all_conds("R10 after mid reset");
    step(1'b0, '0, 1'b0, 0, "R11 tail");
    step(1'b0, '0, 1'b0, 0, "R11 tail");
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule